// File: doc/BRIEF.md
# Duty-Cycled Standby Wake Controller

This block decides the power mode of a battery-powered audio transmitter. In full mode the radio synthesizer and the output power amplifier are kept on, together with the microphone amplifier and the sample converter. A timer of whole milliseconds runs during full mode and is restarted by every audio-detect strobe. When it reaches a programmed limit, the controller drops to standby. In standby the radio path is off. The microphone amplifier and the converter wake for a short listen window at a fixed period, and the amplifier gain is forced to its top setting during that window.

A detect strobe that arrives while a window is open brings the controller back to full mode. It also issues a single-cycle wake pulse that starts calibration of the synthesizer. A strobe that arrives while the listen path is powered down has no effect. Each of the four block enables is ANDed with its own software-written allow bit before it leaves the block. The millisecond tick comes from a prescaler on the reference clock. With the default parameters (16,000 cycles per tick, a 1-tick window, a 100-tick period) this gives a 1 ms window every 100 ms on a 16 MHz clock.

Top module: `pmc_standby_ctrl`

## Requirements
- R1: During and after reset the controller is in full mode. With all allow bits set, all four enables are high, the gain override is low and the wake pulse is low. Reset does not produce a wake pulse.
- R2: With no detect strobe, standby is entered exactly `idle_limit_i * TICK_CYCLES` clock edges after reset release, after the wake edge, or after the last strobe. A limit of 0 behaves like a limit of 1.
- R3: A detect strobe in full mode restarts the idle timeout from zero, so the controller stays in full mode.
- R4: In standby the synthesizer enable and the power-amplifier enable are low.
- R5: Count k as the number of edges since standby entry, with k = 0 just after the entry edge. Amplifier and converter enables and the gain override are high when `k mod (PERIOD_TICKS*TICK_CYCLES) < WIN_TICKS*TICK_CYCLES`, and low otherwise.
- R6: A detect strobe sampled while the listen window is open returns the controller to full mode at that edge. All enables come back and the gain override goes low.
- R7: A detect strobe sampled in standby while the window is closed is ignored, and the listen schedule continues unchanged.
- R8: On every standby-to-full transition, `wake_o` is high for exactly one cycle.
- R9: The allow bits map as bit 0 synthesizer, bit 1 power amplifier, bit 2 microphone amplifier, bit 3 converter. Each output enable is the mode-derived enable ANDed with its bit. The gain override is not masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| detect_i | input | 1 | One-cycle audio-detected strobe |
| idle_limit_i | input | LIMIT_W | Idle timeout in ticks |
| blk_allow_i | input | 4 | Per-block allow bits from software |
| en_synth_o | output | 1 | Synthesizer enable |
| en_pa_o | output | 1 | Power-amplifier enable |
| en_amp_o | output | 1 | Microphone-amplifier enable |
| en_adc_o | output | 1 | Converter enable |
| gain_max_o | output | 1 | Force amplifier gain to maximum |
| wake_o | output | 1 | One-cycle pulse on return to full mode |

## Verification
The bench uses a small configuration: 4 cycles per tick, a 2-tick window, a 5-tick period and an idle limit of 3. The timeout is first run with no strobe at all, to pin down the exact edge of shutdown. It is then run with a strobe in the middle of the count, to separate a restart of the timer from a timer that simply keeps counting. In standby, every cycle of two full periods is compared against the arithmetic window formula. Strobes placed in the closed part of a period show whether they are ignored. A strobe inside an open window shows the wake path and the single-cycle width of its pulse. All 16 allow patterns are swept both in a listen window and in full mode, which separates the bit order and the AND from the mode logic. A final run with a limit of zero covers the shortest timeout.

// File: rtl/pmc_pkg.sv
`timescale 1ns/1ps
package pmc_pkg;

    typedef enum logic {
        MODE_FULL = 1'b0,
        MODE_STBY = 1'b1
    } pmc_mode_e;

    localparam int NBLK    = 4;
    localparam int BLK_SYN = 0;
    localparam int BLK_PA  = 1;
    localparam int BLK_AMP = 2;
    localparam int BLK_ADC = 3;

    typedef struct packed {
        pmc_mode_e mode;
        logic      wake;
    } pmc_fsm_s;

endpackage

// File: rtl/pmc_tick_gen.sv
`timescale 1ns/1ps
module pmc_tick_gen #(
    parameter int TICK_CYCLES = 16000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic tick_o
);
    localparam int CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick_o = (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q + 1'b1;
        if (restart_i || tick_o) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/pmc_idle_timer.sv
`timescale 1ns/1ps
module pmc_idle_timer #(
    parameter int LIMIT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  logic               tick_i,
    input  logic [LIMIT_W-1:0] limit_i,
    output logic               expire_o
);
    logic [LIMIT_W-1:0] cnt_d, cnt_q;
    logic [LIMIT_W:0]   next_cnt;

    assign next_cnt = {1'b0, cnt_q} + 1'b1;
    assign expire_o = tick_i && !clear_i && (next_cnt >= {1'b0, limit_i});

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (tick_i && !expire_o) begin
            cnt_d = next_cnt[LIMIT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/pmc_listen_seq.sv
`timescale 1ns/1ps
module pmc_listen_seq #(
    parameter int WIN_TICKS    = 1,
    parameter int PERIOD_TICKS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic tick_i,
    output logic window_o
);
    localparam int PW = (PERIOD_TICKS > 1) ? $clog2(PERIOD_TICKS) : 1;
    localparam logic [PW:0] WIN_END = (PW + 1)'(WIN_TICKS);
    localparam logic [PW-1:0] PH_LAST = PW'(PERIOD_TICKS - 1);

    logic [PW-1:0] phase_d, phase_q;

    assign window_o = ({1'b0, phase_q} < WIN_END);

    always_comb begin
        phase_d = phase_q;
        if (clear_i) begin
            phase_d = '0;
        end else if (tick_i) begin
            phase_d = (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_d;
        end
    end
endmodule

// File: rtl/pmc_standby_ctrl.sv
`timescale 1ns/1ps
module pmc_standby_ctrl #(
    parameter int TICK_CYCLES  = 16000,
    parameter int WIN_TICKS    = 1,
    parameter int PERIOD_TICKS = 100,
    parameter int LIMIT_W      = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               detect_i,
    input  logic [LIMIT_W-1:0] idle_limit_i,
    input  logic [3:0]         blk_allow_i,
    output logic               en_synth_o,
    output logic               en_pa_o,
    output logic               en_amp_o,
    output logic               en_adc_o,
    output logic               gain_max_o,
    output logic               wake_o
);
    import pmc_pkg::*;

    pmc_fsm_s st_d, st_q;
    logic is_full;
    logic tick;
    logic expire;
    logic win;
    logic go_stby, go_full;
    logic presc_restart;
    logic idle_clear;
    logic [NBLK-1:0] raw_en, gated_en;

    assign is_full = (st_q.mode == MODE_FULL);

    always_comb begin
        st_d      = st_q;
        st_d.wake = 1'b0;
        go_stby   = 1'b0;
        go_full   = 1'b0;
        case (st_q.mode)
            MODE_FULL: begin
                if (expire) begin
                    st_d.mode = MODE_STBY;
                    go_stby   = 1'b1;
                end
            end
            MODE_STBY: begin
                if (win && detect_i) begin
                    st_d.mode = MODE_FULL;
                    st_d.wake = 1'b1;
                    go_full   = 1'b1;
                end
            end
            default: st_d.mode = MODE_FULL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_FULL, wake: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign presc_restart = go_stby || go_full || (is_full && detect_i);
    assign idle_clear    = !is_full || detect_i;

    pmc_tick_gen #(
        .TICK_CYCLES(TICK_CYCLES)
    ) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart_i(presc_restart),
        .tick_o   (tick)
    );

    pmc_idle_timer #(
        .LIMIT_W(LIMIT_W)
    ) u_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (idle_clear),
        .tick_i  (tick),
        .limit_i (idle_limit_i),
        .expire_o(expire)
    );

    pmc_listen_seq #(
        .WIN_TICKS   (WIN_TICKS),
        .PERIOD_TICKS(PERIOD_TICKS)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (is_full),
        .tick_i  (tick),
        .window_o(win)
    );

    always_comb begin
        raw_en          = '0;
        raw_en[BLK_SYN] = is_full;
        raw_en[BLK_PA]  = is_full;
        raw_en[BLK_AMP] = is_full || win;
        raw_en[BLK_ADC] = is_full || win;
    end

    for (genvar b = 0; b < NBLK; b++) begin : g_gate
        assign gated_en[b] = raw_en[b] & blk_allow_i[b];
    end

    assign en_synth_o = gated_en[BLK_SYN];
    assign en_pa_o    = gated_en[BLK_PA];
    assign en_amp_o   = gated_en[BLK_AMP];
    assign en_adc_o   = gated_en[BLK_ADC];
    assign gain_max_o = !is_full && win;
    assign wake_o     = st_q.wake;
endmodule

// File: rtl/pmc_standby_chk.sv
`timescale 1ns/1ps
module pmc_standby_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       detect_i,
    input logic [3:0] blk_allow_i,
    input logic       en_synth_o,
    input logic       en_pa_o,
    input logic       en_amp_o,
    input logic       en_adc_o,
    input logic       gain_max_o,
    input logic       wake_o,
    input logic       is_full,
    input logic       win
);
    a_r4_radio_off: assert property (@(posedge clk) disable iff (!rst_n)
        !is_full |-> (!en_synth_o && !en_pa_o));

    a_r5_gain_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        gain_max_o |-> (!is_full && win));

    a_r3_detect_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
        (is_full && detect_i) |=> is_full);

    a_r6_window_wakes: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_full && win && detect_i) |=> (is_full && wake_o));

    a_r7_closed_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_full && !win) |=> !is_full);

    a_r8_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> !wake_o);

    a_r8_wake_from_standby: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> (is_full && $past(!is_full)));

    a_r9_allow_gates: assert property (@(posedge clk) disable iff (!rst_n)
        (!blk_allow_i[0] |-> !en_synth_o) and (!blk_allow_i[1] |-> !en_pa_o) and
        (!blk_allow_i[2] |-> !en_amp_o) and (!blk_allow_i[3] |-> !en_adc_o));
endmodule

bind pmc_standby_ctrl pmc_standby_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .detect_i   (detect_i),
    .blk_allow_i(blk_allow_i),
    .en_synth_o (en_synth_o),
    .en_pa_o    (en_pa_o),
    .en_amp_o   (en_amp_o),
    .en_adc_o   (en_adc_o),
    .gain_max_o (gain_max_o),
    .wake_o     (wake_o),
    .is_full    (is_full),
    .win        (win)
);

// File: tb/sim_pmc_standby_ctrl.sv
`timescale 1ns/1ps
module sim_pmc_standby_ctrl;
    localparam int T  = 4;
    localparam int W  = 2;
    localparam int P  = 5;
    localparam int LW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic detect = 1'b0;
    logic [LW-1:0] limit = 8'd3;
    logic [3:0] allow = 4'hF;
    logic en_synth, en_pa, en_amp, en_adc, gain_max, wake;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pmc_standby_ctrl #(
        .TICK_CYCLES(T), .WIN_TICKS(W), .PERIOD_TICKS(P), .LIMIT_W(LW)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .detect_i(detect), .idle_limit_i(limit),
        .blk_allow_i(allow), .en_synth_o(en_synth), .en_pa_o(en_pa),
        .en_amp_o(en_amp), .en_adc_o(en_adc), .gain_max_o(gain_max), .wake_o(wake)
    );

    // {synth, pa, amp, adc, gain_max, wake}
    function automatic logic [5:0] exp_full(input logic wk);
        return {5'b11110, wk};
    endfunction

    function automatic logic [5:0] exp_stby(input int k);
        return ((k % (P * T)) < (W * T)) ? 6'b001110 : 6'b000000;
    endfunction

    task automatic chk(input string tag, input logic [5:0] exp);
        logic [5:0] got;
        got = {en_synth, en_pa, en_amp, en_adc, gain_max, wake};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R1 in reset", exp_full(1'b0));
        rst_n = 1'b1;

        // R2: timeout of limit*T edges after reset release
        for (int n = 1; n <= 3 * T; n++) begin
            step();
            chk(n < 3 * T ? "R1/R2 full before timeout" : "R2 standby at timeout",
                n < 3 * T ? exp_full(1'b0) : exp_stby(0));
        end

        // R4, R5 window schedule, R7 strobes in closed part ignored
        for (int k = 1; k <= 41; k++) begin
            detect = (k == 11 || k == 31);
            step();
            chk(detect ? "R7 closed-window strobe ignored" :
                (exp_stby(k - 0) != 0 ? "R5 listen window" : "R4 standby quiet"),
                exp_stby(k));
        end

        // R6, R8: strobe inside an open window (state after k=41 is open)
        detect = 1'b1;
        step();
        chk("R6/R8 wake in window", exp_full(1'b1));
        detect = 1'b0;

        // R3: strobe restarts the timeout
        for (int j = 1; j <= 17; j++) begin
            detect = (j == 5);
            step();
            chk(j < 17 ? "R3/R8 full after restart" : "R3 standby after restarted timeout",
                j < 17 ? exp_full(1'b0) : exp_stby(0));
        end
        detect = 1'b0;

        // R9: allow sweep inside a listen window
        for (int m = 0; m < 16; m++) begin
            allow = 4'(m);
            #0.25;
            chk("R9 allow in window", {2'b00, allow[2], allow[3], 2'b10});
        end
        allow = 4'hF;
        detect = 1'b1;
        step();
        detect = 1'b0;
        chk("R6/R8 second wake", exp_full(1'b1));

        // R9: allow sweep in full mode
        for (int m = 0; m < 16; m++) begin
            allow = 4'(m);
            #0.25;
            chk("R9 allow in full", {allow[0], allow[1], allow[2], allow[3], 2'b01});
        end
        allow = 4'hF;
        limit = '0;

        // R2: limit 0 behaves like 1
        for (int j = 1; j <= T; j++) begin
            step();
            chk(j < T ? "R2/R8 full with zero limit" : "R2 zero limit timeout",
                j < T ? exp_full(1'b0) : exp_stby(0));
        end

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule